// File: doc/BRIEF.md
# PS/2 Mouse Device Command Processor

This block is the protocol engine on the device side of a PS/2 pointing device. A serial link front end hands it each byte received from the host, along with a flag that marks a parity or framing fault. The block decodes the mouse command set and holds the operating state: the reporting mode (stream or remote), the wrap (loopback) mode, the reporting enable, the sample rate, the resolution and the autospeed setting. It builds response packets and passes them to the link one byte at a time over a request/acknowledge pair. It also keeps the two most recent packets so that a host retransmission request can be answered.

A movement accumulator beside the block supplies the signed X/Y counts, their overflow flags and the button levels. The block drives the accumulator's mode inputs and issues a one-cycle clear strobe whenever the counts have been consumed. In stream mode the block counts periodic timer ticks and sends a 3-byte movement report at the programmed rate. A report goes out only when there is movement or the buttons have changed since the last report.

Top module: `ps2_mouse_cmd`

## Requirements
- R1: After reset the block is in stream mode with reporting disabled, autospeed off, resolution code 2, sample rate 0x64, wrap off and no byte pending. A status request (E9) in this state returns FA, 0x00 (no buttons), 0x02, 0x64.
- R2: Command FF returns FA, AA, 00 and restores every default listed in R1. This also applies when FF is received in wrap mode, which the command leaves.
- R3: Command F6 returns FA and restores the R1 defaults.
- R4: Commands F4/F5 set/clear the reporting enable, F0/EA select remote/stream mode, and E7/E6 set/clear autospeed. Each is answered with a single FA.
- R5: F3 is answered with FA and makes the next byte a rate argument. A rate byte of 0A, 14, 28, 3C, 50, 64 or C8 is stored and answered with FA. Any other rate byte is answered as invalid (R7), leaves the stored rate unchanged, and keeps the block waiting for a rate byte.
- R6: E8 is answered with FA and makes the next byte a resolution argument. A value from 00 to 03 is stored in the resolution output and answered with FA. Any other value is answered as invalid and leaves the resolution unchanged.
- R7: A byte flagged with a link error, or an unknown command, is answered with FE. A second such byte directly after the first is answered with FC, and the run then starts over. Any valid byte ends the run.
- R8: Resend (FE) retransmits the last packet sent. If that packet was the single byte FE, the packet sent before it is retransmitted instead. A resend does not change which packets are remembered.
- R9: EE is answered with FA and enters wrap mode. In wrap mode each received byte is echoed unchanged, except EC, which is answered with FA and restores the previous remote/stream mode, and FF (R2).
- R10: F2 returns FA, 00. EB returns FA followed by a 3-byte report in either mode. Report byte 1 has bit0 left, bit1 right, bit2 middle, bit3 set to 1, bit4 X sign, bit5 Y sign, bit6 X overflow and bit7 Y overflow. Bytes 2 and 3 are the low eight bits of X and Y.
- R11: E9 returns FA and 3 status bytes. Byte 1 has bit0 right, bit1 middle, bit2 left, bit4 autospeed, bit5 enable and bit6 remote, with the other bits 0. Byte 2 is the resolution code and byte 3 is the rate byte.
- R12: clr_o pulses for one cycle for every byte accepted without error, except a Resend command outside wrap mode. It also pulses for every stream report sent.
- R13: In stream mode, with reporting enabled, outside wrap mode and with no argument pending, the block sends a 3-byte report (R10 layout) at the end of each interval of TICK_HZ/rate ticks, but only if X or Y is non-zero or the buttons differ from the last report. It sends no report when disabled.
- R14: While tx_req_o is high, tx_byte_o holds its value until tx_ack_i takes it, unless a new packet replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a host byte has arrived |
| rx_byte_i | input | 8 | Received host byte |
| rx_err_i | input | 1 | Received byte had a parity or framing fault |
| tx_req_o | output | 1 | A response byte is waiting for the link |
| tx_byte_o | output | 8 | Response byte to transmit |
| tx_ack_i | input | 1 | Link has taken tx_byte_o |
| tick_i | input | 1 | Periodic timer tick, TICK_HZ per second |
| btn_i | input | 3 | Button levels: bit0 left, bit1 right, bit2 middle |
| dx_i | input | 9 | Accumulated X count, two's complement |
| dy_i | input | 9 | Accumulated Y count, two's complement |
| x_ovf_i | input | 1 | X count overflowed |
| y_ovf_i | input | 1 | Y count overflowed |
| remote_o | output | 1 | Remote mode selected |
| enable_o | output | 1 | Stream reporting enabled |
| wrap_o | output | 1 | Wrap mode active |
| autospeed_o | output | 1 | Autospeed scaling on |
| res_o | output | 2 | Resolution code |
| clr_o | output | 1 | One-cycle clear strobe for the accumulator |

## Verification
The bench builds the block with TICK_HZ = 200. At that setting the default rate gives a report interval of two ticks, and the fastest legal rate gives one tick, so stream timing can be checked over a handful of tick pulses rather than hundreds. The other default parameters keep the four-byte packet limit, so the longest response (acknowledge plus report or status) fills the buffer exactly. That lets the resend history be tested on packets of one, two and four bytes.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  typedef logic [7:0] byte_t;

  localparam int unsigned PKT_MAX = 4;
  localparam int unsigned LEN_W   = $clog2(PKT_MAX + 1);
  localparam int unsigned IDX_W   = $clog2(PKT_MAX);

  typedef byte_t [PKT_MAX-1:0] pkt_t;

  typedef enum logic [1:0] {ARG_NONE, ARG_RATE, ARG_RES} arg_e;

  localparam byte_t ACK       = 8'hFA;
  localparam byte_t NAK       = 8'hFE;
  localparam byte_t ERR2      = 8'hFC;
  localparam byte_t SELF_OK   = 8'hAA;
  localparam byte_t DEV_ID    = 8'h00;
  localparam byte_t RATE_DFLT = 8'h64;
  localparam logic [1:0] RES_DFLT = 2'd2;

  function automatic logic rate_legal(input byte_t r);
    case (r)
      8'h0A, 8'h14, 8'h28, 8'h3C, 8'h50, 8'h64, 8'hC8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ps2m_txq.sv
module ps2m_txq
  import ps2m_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  pkt_t             pkt_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             resend_i,
  input  logic             ack_i,
  output logic             req_o,
  output byte_t            byte_o,
  output logic             busy_o
);
  pkt_t             cur_q, last_q, prev_q;
  logic [LEN_W-1:0] cur_len_q, last_len_q, prev_len_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             last_is_nak;

  assign last_is_nak = (last_len_q == LEN_W'(1)) && (last_q[0] == NAK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0; last_q <= '0; prev_q <= '0;
      cur_len_q <= '0; last_len_q <= '0; prev_len_q <= '0;
      idx_q <= '0; busy_q <= 1'b0;
    end else if (load_i) begin
      cur_q      <= pkt_i;
      cur_len_q  <= len_i;
      idx_q      <= '0;
      busy_q     <= (len_i != '0);
      prev_q     <= last_q;
      prev_len_q <= last_len_q;
      last_q     <= pkt_i;
      last_len_q <= len_i;
    end else if (resend_i) begin
      // history is left untouched by a replay
      idx_q <= '0;
      if (last_is_nak) begin
        cur_q <= prev_q; cur_len_q <= prev_len_q; busy_q <= (prev_len_q != '0);
      end else begin
        cur_q <= last_q; cur_len_q <= last_len_q; busy_q <= (last_len_q != '0);
      end
    end else if (busy_q && ack_i) begin
      if (LEN_W'(idx_q) + LEN_W'(1) == cur_len_q) busy_q <= 1'b0;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign req_o  = busy_q;
  assign byte_o = cur_q[idx_q];
  assign busy_o = busy_q;

  // R14
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !load_i && !resend_i) |=> (req_o && $stable(byte_o)));
endmodule

// File: rtl/ps2m_rate.sv
module ps2m_rate
  import ps2m_pkg::*;
#(
  parameter int unsigned TICK_HZ = 1000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  restart_i,
  input  byte_t rate_i,
  output logic  due_o
);
  localparam int unsigned MAX_IV = (TICK_HZ / 10 > 0) ? TICK_HZ / 10 : 1;
  localparam int unsigned CW     = $clog2(MAX_IV + 1);

  function automatic logic [CW-1:0] interval(input byte_t r);
    int unsigned v;
    case (r)
      8'h0A:   v = TICK_HZ / 10;
      8'h14:   v = TICK_HZ / 20;
      8'h28:   v = TICK_HZ / 40;
      8'h3C:   v = TICK_HZ / 60;
      8'h50:   v = TICK_HZ / 80;
      8'hC8:   v = TICK_HZ / 200;
      default: v = TICK_HZ / 100;
    endcase
    if (v == 0) v = 1;
    return CW'(v);
  endfunction

  logic [CW-1:0] cnt_q, lim;
  logic          due_q;

  assign lim = interval(rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; due_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0; due_q <= 1'b0;
    end else begin
      due_q <= 1'b0;
      if (tick_i) begin
        if (cnt_q + CW'(1) >= lim) begin
          cnt_q <= '0; due_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign due_o = due_q;

  // R13
  due_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |-> $past(tick_i));
endmodule

// File: rtl/ps2_mouse_cmd.sv
module ps2_mouse_cmd
  import ps2m_pkg::*;
#(
  parameter int unsigned TICK_HZ = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  input  logic       rx_err_i,
  output logic       tx_req_o,
  output logic [7:0] tx_byte_o,
  input  logic       tx_ack_i,
  input  logic       tick_i,
  input  logic [2:0] btn_i,
  input  logic [8:0] dx_i,
  input  logic [8:0] dy_i,
  input  logic       x_ovf_i,
  input  logic       y_ovf_i,
  output logic       remote_o,
  output logic       enable_o,
  output logic       wrap_o,
  output logic       autospeed_o,
  output logic [1:0] res_o,
  output logic       clr_o
);
  logic       remote_q, en_q, wrap_q, auto_q, errp_q;
  logic [1:0] res_q;
  byte_t      rate_q;
  arg_e       arg_q;
  logic [2:0] lbtn_q;

  logic       n_remote, n_en, n_wrap, n_auto, n_errp;
  logic [1:0] n_res;
  byte_t      n_rate;
  arg_e       n_arg;
  logic [2:0] n_lbtn;

  logic             ld, rs, clr, rrst, bad, dflt, due, busy;
  pkt_t             pkt;
  logic [LEN_W-1:0] len;
  byte_t            rep_b0, stat_b0;

  assign rep_b0  = {y_ovf_i, x_ovf_i, dy_i[8], dx_i[8], 1'b1, btn_i[2], btn_i[1], btn_i[0]};
  assign stat_b0 = {1'b0, remote_q, en_q, auto_q, 1'b0, btn_i[0], btn_i[2], btn_i[1]};

  always_comb begin
    n_remote = remote_q; n_en = en_q; n_wrap = wrap_q; n_auto = auto_q;
    n_errp = errp_q; n_res = res_q; n_rate = rate_q; n_arg = arg_q; n_lbtn = lbtn_q;
    ld = 1'b0; rs = 1'b0; clr = 1'b0; rrst = 1'b0; bad = 1'b0; dflt = 1'b0;
    pkt = '0; len = '0;
    if (rx_valid_i) begin
      pkt[0] = ACK;
      len    = LEN_W'(1);
      if (rx_err_i) begin
        bad = 1'b1;
      end else if (wrap_q) begin
        if (rx_byte_i == 8'hFF) begin
          dflt = 1'b1; pkt[1] = SELF_OK; pkt[2] = DEV_ID; len = LEN_W'(3);
        end else if (rx_byte_i == 8'hEC) begin
          n_wrap = 1'b0;
        end else begin
          pkt[0] = rx_byte_i;
        end
      end else if (arg_q == ARG_RATE) begin
        if (rate_legal(rx_byte_i)) begin
          n_rate = rx_byte_i; rrst = 1'b1; n_arg = ARG_NONE;
        end else bad = 1'b1;
      end else if (arg_q == ARG_RES) begin
        if (rx_byte_i[7:2] == '0) begin
          n_res = rx_byte_i[1:0]; n_arg = ARG_NONE;
        end else bad = 1'b1;
      end else begin
        case (rx_byte_i)
          8'hFF: begin dflt = 1'b1; pkt[1] = SELF_OK; pkt[2] = DEV_ID; len = LEN_W'(3); end
          8'hFE: rs = 1'b1;
          8'hF6: dflt = 1'b1;
          8'hF5: n_en = 1'b0;
          8'hF4: n_en = 1'b1;
          8'hF3: n_arg = ARG_RATE;
          8'hF2: begin pkt[1] = DEV_ID; len = LEN_W'(2); end
          8'hF0: n_remote = 1'b1;
          8'hEE: n_wrap = 1'b1;
          8'hEC: ;
          8'hEB: begin
            pkt[1] = rep_b0; pkt[2] = dx_i[7:0]; pkt[3] = dy_i[7:0];
            len = LEN_W'(4); n_lbtn = btn_i;
          end
          8'hEA: n_remote = 1'b0;
          8'hE9: begin
            pkt[1] = stat_b0; pkt[2] = {6'b0, res_q}; pkt[3] = rate_q; len = LEN_W'(4);
          end
          8'hE8: n_arg = ARG_RES;
          8'hE7: n_auto = 1'b1;
          8'hE6: n_auto = 1'b0;
          default: bad = 1'b1;
        endcase
      end
      if (bad) begin
        ld = 1'b1; pkt = '0; pkt[0] = errp_q ? ERR2 : NAK; len = LEN_W'(1);
        n_errp = !errp_q;
      end else begin
        n_errp = 1'b0;
        if (!rs) begin ld = 1'b1; clr = 1'b1; end
      end
    end else if (due && !remote_q && en_q && !wrap_q && !busy && arg_q == ARG_NONE &&
                 (dx_i != '0 || dy_i != '0 || btn_i != lbtn_q)) begin
      ld = 1'b1; clr = 1'b1; n_lbtn = btn_i;
      pkt[0] = rep_b0; pkt[1] = dx_i[7:0]; pkt[2] = dy_i[7:0]; len = LEN_W'(3);
    end
    if (dflt) begin
      n_rate = RATE_DFLT; n_auto = 1'b0; n_remote = 1'b0; n_res = RES_DFLT;
      n_en = 1'b0; n_wrap = 1'b0; n_arg = ARG_NONE; rrst = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remote_q <= 1'b0; en_q <= 1'b0; wrap_q <= 1'b0; auto_q <= 1'b0; errp_q <= 1'b0;
      res_q <= RES_DFLT; rate_q <= RATE_DFLT; arg_q <= ARG_NONE; lbtn_q <= '0;
    end else begin
      remote_q <= n_remote; en_q <= n_en; wrap_q <= n_wrap; auto_q <= n_auto;
      errp_q <= n_errp; res_q <= n_res; rate_q <= n_rate; arg_q <= n_arg; lbtn_q <= n_lbtn;
    end
  end

  ps2m_txq u_txq (
    .clk_i, .rst_ni, .load_i(ld), .pkt_i(pkt), .len_i(len), .resend_i(rs),
    .ack_i(tx_ack_i), .req_o(tx_req_o), .byte_o(tx_byte_o), .busy_o(busy)
  );

  ps2m_rate #(.TICK_HZ(TICK_HZ)) u_rate (
    .clk_i, .rst_ni, .tick_i, .restart_i(rrst), .rate_i(rate_q), .due_o(due)
  );

  assign remote_o    = remote_q;
  assign enable_o    = en_q;
  assign wrap_o      = wrap_q;
  assign autospeed_o = auto_q;
  assign res_o       = res_q;
  assign clr_o       = clr;

  // R12
  resend_noclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !rx_err_i && !wrap_o && arg_q == ARG_NONE && rx_byte_i == 8'hFE) |-> !clr_o);
  // R9
  wrap_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_o) |-> $past(rx_valid_i && rx_byte_i == 8'hEE));
  // R6
  res_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> $past(rx_valid_i));
endmodule

// File: tb/ps2_mouse_cmd_tb.sv
`timescale 1ns/1ps
module ps2_mouse_cmd_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_err = 1'b0, tx_ack = 1'b0, tick = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_req;
  logic [7:0] tx_byte;
  logic [2:0] btn = '0;
  logic [8:0] dx = '0, dy = '0;
  logic       x_ovf = 1'b0, y_ovf = 1'b0;
  logic       remote, enable, wrap, autosp, clr;
  logic [1:0] res;

  int n_chk = 0, n_fail = 0, clr_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R1";

  always #2 clk = ~clk;

  ps2_mouse_cmd #(.TICK_HZ(200)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_err_i(rx_err),
    .tx_req_o(tx_req), .tx_byte_o(tx_byte), .tx_ack_i(tx_ack), .tick_i(tick), .btn_i(btn),
    .dx_i(dx), .dy_i(dy), .x_ovf_i(x_ovf), .y_ovf_i(y_ovf), .remote_o(remote),
    .enable_o(enable), .wrap_o(wrap), .autospeed_o(autosp), .res_o(res), .clr_o(clr)
  );

  // monitor: pops expected bytes and acknowledges each one
  initial begin
    forever begin
      @(negedge clk);
      tx_ack = 1'b0;
      if (clr) clr_cnt++;
      if (rst_n && tx_req) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL %s unexpected tx byte act=%02h exp=none", cur_tag, tx_byte);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          if (tx_byte !== e) begin
            n_fail++;
            $display("FAIL %s tx byte act=%02h exp=%02h", t, tx_byte, e);
          end
        end
        tx_ack = 1'b1;
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic expect_b(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [7:0] b, input logic e = 1'b0);
    @(negedge clk);
    rx_byte = b; rx_err = e; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || tx_req) && n < 300) begin
      @(negedge clk); n++;
    end
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s missing bytes act=%0d exp=0", cur_tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic cmd1(input logic [7:0] b, input string t);
    cur_tag = t;
    expect_b(8'hFA, t);
    send(b);
    drain();
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 mode outputs", {10'b0, remote, enable, wrap, autosp, res}, {10'b0, 4'b0000, 2'd2});
    chk("R1 no tx pending", {15'b0, tx_req}, 16'h0);
    cur_tag = "R1";
    expect_b(8'hFA, "R1"); expect_b(8'h00, "R1"); expect_b(8'h02, "R1"); expect_b(8'h64, "R1");
    send(8'hE9); drain();

    // R4 simple mode commands
    c0 = clr_cnt;
    cmd1(8'hF4, "R4");
    chk("R12 clr on F4", 16'(clr_cnt - c0), 16'd1);
    cmd1(8'hE7, "R4");
    cmd1(8'hF0, "R4");
    chk("R4 en/auto/remote", {13'b0, enable, autosp, remote}, 16'b111);

    // R11 status encoding: left+right pressed
    btn = 3'b011;
    cur_tag = "R11";
    expect_b(8'hFA, "R11"); expect_b(8'h75, "R11"); expect_b(8'h02, "R11"); expect_b(8'h64, "R11");
    send(8'hE9); drain();

    // R5 rate argument
    cmd1(8'hF3, "R5");
    cmd1(8'hC8, "R5");
    cmd1(8'hF3, "R5");
    cur_tag = "R5"; expect_b(8'hFE, "R5"); send(8'h55); drain();
    cmd1(8'h28, "R5");

    // R6 resolution argument
    cmd1(8'hE8, "R6");
    cmd1(8'h03, "R6");
    chk("R6 res=3", {14'b0, res}, 16'd3);
    cmd1(8'hE8, "R6");
    cur_tag = "R6"; expect_b(8'hFE, "R6"); send(8'h07); drain();
    chk("R6 res kept", {14'b0, res}, 16'd3);
    cmd1(8'h00, "R6");
    chk("R6 res=0", {14'b0, res}, 16'd0);

    cur_tag = "R11";
    expect_b(8'hFA, "R11"); expect_b(8'h75, "R11"); expect_b(8'h00, "R11"); expect_b(8'h28, "R11");
    send(8'hE9); drain();

    // R7 error escalation
    cur_tag = "R7";
    expect_b(8'hFE, "R7"); send(8'h12); drain();
    expect_b(8'hFC, "R7"); send(8'h13); drain();
    expect_b(8'hFE, "R7"); send(8'h14); drain();
    cur_tag = "R10"; expect_b(8'hFA, "R10"); expect_b(8'h00, "R10"); send(8'hF2); drain();
    cur_tag = "R7"; expect_b(8'hFE, "R7"); send(8'hF4, 1'b1); drain();

    // R8 resend skips a prior FE
    c0 = clr_cnt;
    cur_tag = "R8";
    expect_b(8'hFA, "R8"); expect_b(8'h00, "R8"); send(8'hFE); drain();
    expect_b(8'hFA, "R8"); expect_b(8'h00, "R8"); send(8'hFE); drain();
    chk("R12 no clr on resend", 16'(clr_cnt - c0), 16'd0);

    // R10 read data in remote mode
    btn = 3'b100; dx = 9'h1F0; dy = 9'd5; x_ovf = 1'b1;
    c0 = clr_cnt;
    cur_tag = "R10";
    expect_b(8'hFA, "R10"); expect_b(8'h5C, "R10"); expect_b(8'hF0, "R10"); expect_b(8'h05, "R10");
    send(8'hEB); drain();
    chk("R12 clr on EB", 16'(clr_cnt - c0), 16'd1);
    dx = '0; dy = '0; x_ovf = 1'b0;

    // R9 wrap mode
    cmd1(8'hEE, "R9");
    chk("R9 wrap on", {15'b0, wrap}, 16'd1);
    cur_tag = "R9";
    expect_b(8'h33, "R9"); send(8'h33); drain();
    expect_b(8'hF4, "R9"); send(8'hF4); drain();
    cmd1(8'hEC, "R9");
    chk("R9 wrap off, remote kept", {14'b0, wrap, remote}, 16'b01);
    cmd1(8'hEE, "R9");
    cur_tag = "R2";
    expect_b(8'hFA, "R2"); expect_b(8'hAA, "R2"); expect_b(8'h00, "R2");
    send(8'hFF); drain();
    chk("R2 defaults", {10'b0, remote, enable, wrap, autosp, res}, {10'b0, 4'b0000, 2'd2});

    // R3 set default
    cmd1(8'hF4, "R3");
    cmd1(8'hE7, "R3");
    cmd1(8'hE8, "R3");
    cmd1(8'h01, "R3");
    cmd1(8'hF6, "R3");
    chk("R3 defaults", {10'b0, remote, enable, wrap, autosp, res}, {10'b0, 4'b0000, 2'd2});

    // R13 stream reports, interval 2 ticks at rate 0x64
    cmd1(8'hF4, "R13");
    cur_tag = "R13";
    btn = 3'b100;
    repeat (4) pulse_tick();
    drain();
    dx = 9'd3;
    pulse_tick();
    c0 = clr_cnt;
    expect_b(8'h0C, "R13"); expect_b(8'h03, "R13"); expect_b(8'h00, "R13");
    pulse_tick();
    drain();
    chk("R12 clr on report", 16'(clr_cnt - c0), 16'd1);
    dx = '0;
    cmd1(8'hF5, "R13");
    dx = 9'd3;
    cur_tag = "R13";
    repeat (2) pulse_tick();
    drain();
    chk("R13 disabled", {15'b0, enable}, 16'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule